// File: doc/BRIEF.md
# GPIO Edge Detector and Interrupt Aggregator

This block watches up to 128 general-purpose pin levels, arranged as four banks of 32, and turns selected level transitions into interrupts. Each pin has a direction bit and separate rising and falling enables. A transition on a pin configured as an input, with the matching enable set, latches a sticky status bit for that pin. Software clears status bits by pulsing a clear strobe together with a per-bit mask. Pin levels reach this block already synchronised to its clock.

The status vector drives three registered interrupt lines. Pin 0 has its own line, pin 1 has its own line, and all remaining pins share one OR-ed line. When the core is halted, a level change on a wake-capable input pin produces a single-cycle wake request. The set of wake-capable pins is a fixed build-time mask. Pins at or above the configured line count are treated as absent.

Top module: `gpio_evt_agg`

## Requirements
- R1: A pin's status bit becomes 1 at the clock edge that sees its level go from 0 to 1, if its rising enable is 1, its direction bit is 0 (input) and its index is below LINES.
- R2: A pin's status bit becomes 1 at the clock edge that sees its level go from 1 to 0, if its falling enable is 1, its direction bit is 0 and its index is below LINES.
- R3: A pin whose direction bit is 1 (output) never sets status. The previous-level history tracks every pin on every cycle, so switching a steady pin from output to input creates no edge.
- R4: Status bits are sticky. At an edge with clr_strobe high, each bit whose clr_mask bit is 1 clears. With clr_strobe low, clr_mask has no effect.
- R5: When an edge detection and a clear hit the same bit at the same clock edge, the bit ends up set.
- R6: irq_pin0 equals status bit 0 and irq_pin1 equals status bit 1. Both are registered and change at the same edge as the status.
- R7: irq_shared is 1 exactly when any status bit from 2 through 127 is 1.
- R8: wake_req is 1 for the cycle after an edge at which core_halted was 1 and a pin below LINES, with direction 0 and wake-mask bit 1, changed level. Default wake mask, bank 0 in bits 31:0 up to bank 3 in bits 127:96: 0x8003FE1B, 0x002001FC, 0xEC080000, 0x0012007F.
- R9: Pins with index at or above LINES (default 116) never set status and never raise wake_req.
- R10: Reset clears status, all interrupts and wake_req. The first clock edge after reset only loads the level history and detects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | 128 | Synchronised pin levels |
| pin_is_out | input | 128 | Direction per pin, 1 = output |
| rise_en | input | 128 | Rising-edge enable per pin |
| fall_en | input | 128 | Falling-edge enable per pin |
| core_halted | input | 1 | Core is halted |
| clr_strobe | input | 1 | Qualifies clr_mask for one cycle |
| clr_mask | input | 128 | Status bits to clear (1 = clear) |
| evt_status | output | 128 | Sticky edge status per pin |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Interrupt for pins 2 and above |
| wake_req | output | 1 | Single-cycle wake request |

## Verification
A clear strobe can hit a status bit in the same cycle that a new edge on that pin sets it. The bench provokes this directly by raising pin 7 with its clear bit asserted, and by dropping pin 40 while it is being cleared. In both cases it expects the bit to stay set. The same collision also occurs many times in a long randomised phase where pins, enables and clears all change every cycle. A behavioural reference model judges every one of those cycles on all outputs.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned NUM_PINS  = BANK_W * NUM_BANKS;

  typedef logic [NUM_PINS-1:0] pinvec_t;

  localparam pinvec_t WAKE_DEFAULT = {32'h0012_007F, 32'hEC08_0000,
                                      32'h0020_01FC, 32'h8003_FE1B};

  function automatic pinvec_t live_mask(input int unsigned lines);
    pinvec_t m;
    for (int unsigned i = 0; i < NUM_PINS; i++) m[i] = (i < lines);
    return m;
  endfunction
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_evt_pkg::*;
#(
  parameter int unsigned LINES = 116
) (
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t pin_level,
  input  pinvec_t pin_is_out,
  input  pinvec_t rise_en,
  input  pinvec_t fall_en,
  output pinvec_t det,
  output pinvec_t chg
);
  localparam pinvec_t LIVE = live_mask(LINES);

  pinvec_t prev_q, prev_d;
  logic    primed_q, primed_d;
  pinvec_t active;

  always_comb begin
    active   = LIVE & ~pin_is_out & {NUM_PINS{primed_q}};
    det      = ((pin_level & ~prev_q & rise_en) |
                (~pin_level & prev_q & fall_en)) & active;
    chg      = (pin_level ^ prev_q) & active;
    prev_d   = pin_level;
    primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  // R3: an output pin can never be reported as an edge
  assert_out_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (det & pin_is_out) == '0);
endmodule

// File: rtl/gpio_status_reg.sv
module gpio_status_reg
  import gpio_evt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t det,
  input  logic    clr_strobe,
  input  pinvec_t clr_mask,
  output pinvec_t status_q,
  output pinvec_t status_d
);
  pinvec_t clr_eff;

  always_comb begin
    clr_eff  = clr_strobe ? clr_mask : '0;
    status_d = (status_q & ~clr_eff) | det;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[b*BANK_W +: BANK_W] <= '0;
      else        status_q[b*BANK_W +: BANK_W] <= status_d[b*BANK_W +: BANK_W];
    end
  end

  // R4: without a strobe no set bit may drop
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_strobe |=> (($past(status_q) & ~status_q) == '0));
  // R5: every detected edge is present after the edge, clear or not
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(det) & ~status_q) == '0));
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine
  import gpio_evt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t status_d,
  input  pinvec_t status_q,
  output logic    irq0_q,
  output logic    irq1_q,
  output logic    irqx_q
);
  logic irq0_d, irq1_d, irqx_d;

  always_comb begin
    irq0_d = status_d[0];
    irq1_d = status_d[1];
    irqx_d = |status_d[NUM_PINS-1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
      irqx_q <= 1'b0;
    end else begin
      irq0_q <= irq0_d;
      irq1_q <= irq1_d;
      irqx_q <= irqx_d;
    end
  end

  // R6: dedicated lines track their status bits
  assert_dedicated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0_q == status_q[0]) && (irq1_q == status_q[1]));
  // R7: shared line tracks the remaining bits
  assert_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irqx_q == (status_q[NUM_PINS-1:2] != '0));
endmodule

// File: rtl/gpio_wake_gen.sv
module gpio_wake_gen
  import gpio_evt_pkg::*;
#(
  parameter pinvec_t WAKE_MASK = WAKE_DEFAULT
) (
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t chg,
  input  logic    halted,
  output logic    wake_q
);
  logic wake_d;

  always_comb wake_d = halted && ((chg & WAKE_MASK) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  // R8: a wake request only follows a halted cycle
  assert_wake_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> $past(halted));
endmodule

// File: rtl/gpio_evt_agg.sv
module gpio_evt_agg
  import gpio_evt_pkg::*;
#(
  parameter int unsigned LINES     = 116,
  parameter pinvec_t     WAKE_MASK = WAKE_DEFAULT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] pin_is_out,
  input  logic [NUM_PINS-1:0] rise_en,
  input  logic [NUM_PINS-1:0] fall_en,
  input  logic                core_halted,
  input  logic                clr_strobe,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] evt_status,
  output logic                irq_pin0,
  output logic                irq_pin1,
  output logic                irq_shared,
  output logic                wake_req
);
  localparam pinvec_t LIVE = live_mask(LINES);

  pinvec_t det, chg, status_q, status_d;

  gpio_edge_detect #(.LINES(LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_is_out(pin_is_out),
    .rise_en(rise_en), .fall_en(fall_en), .det(det), .chg(chg));

  gpio_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .det(det), .clr_strobe(clr_strobe),
    .clr_mask(clr_mask), .status_q(status_q), .status_d(status_d));

  gpio_irq_combine u_irq (
    .clk(clk), .rst_n(rst_n), .status_d(status_d), .status_q(status_q),
    .irq0_q(irq_pin0), .irq1_q(irq_pin1), .irqx_q(irq_shared));

  gpio_wake_gen #(.WAKE_MASK(WAKE_MASK)) u_wake (
    .clk(clk), .rst_n(rst_n), .chg(chg), .halted(core_halted), .wake_q(wake_req));

  assign evt_status = status_q;

  // R9: absent pins never hold status
  assert_absent_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_status & ~LIVE) == '0);
endmodule

// File: tb/sim_gpio_evt_agg.sv
`timescale 1ns/1ps
module sim_gpio_evt_agg;
  localparam int N = 128;
  localparam int LN = 116;
  localparam logic [N-1:0] WM = {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin_level = '0, pin_is_out = '0, rise_en = '0, fall_en = '0, clr_mask = '0;
  logic core_halted = 1'b0, clr_strobe = 1'b0;
  logic [N-1:0] evt_status;
  logic irq_pin0, irq_pin1, irq_shared, wake_req;

  always #5 clk = ~clk;

  gpio_evt_agg u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  logic [N-1:0] m_prev, m_stat;
  bit m_primed, m_wake;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_stat = '0; m_primed = 0; m_wake = 0;
    end else begin
      m_wake = 0;
      for (int i = 0; i < N; i++) begin
        bit act, hit;
        act = m_primed && (i < LN) && !pin_is_out[i];
        hit = act && ((pin_level[i] && !m_prev[i] && rise_en[i]) ||
                      (!pin_level[i] && m_prev[i] && fall_en[i]));
        if (clr_strobe && clr_mask[i]) m_stat[i] = 1'b0;
        if (hit) m_stat[i] = 1'b1;
        if (core_halted && act && WM[i] && (pin_level[i] != m_prev[i])) m_wake = 1;
      end
      m_prev = pin_level;
      m_primed = 1;
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1/R2/R3/R4/R5/R9 status", evt_status, m_stat);
    chk("R6 irq_pin0", N'(irq_pin0), N'(m_stat[0]));
    chk("R6 irq_pin1", N'(irq_pin1), N'(m_stat[1]));
    chk("R7 irq_shared", N'(irq_shared), N'(|m_stat[N-1:2]));
    chk("R8 wake_req", N'(wake_req), N'(m_wake));
  end

  task automatic tick(); @(posedge clk); #2; endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pin_level = '1; rise_en = '1;
    #1;
    chk("R10 reset status", evt_status, '0);
    chk("R10 reset irq", N'({irq_pin0, irq_pin1, irq_shared, wake_req}), '0);
    tick(); tick(); rst_n = 1'b1;
    tick(); tick();
    chk("R10 no edge after reset", evt_status, '0);
    pin_level = '0; tick();                                  // falls not enabled
    chk("R2 disabled fall", evt_status, '0);
    pin_level[0] = 1; tick();
    chk("R1 rise pin0", evt_status, N'(1));
    chk("R6 irq0 same edge", N'(irq_pin0), N'(1));
    pin_level[1] = 1; tick();
    chk("R6 irq1", N'(irq_pin1), N'(1));
    chk("R7 shared idle", N'(irq_shared), N'(0));
    pin_is_out[3] = 1; pin_level[3] = 1; tick(); tick();
    chk("R3 output pin", evt_status[3], '0);
    pin_is_out[3] = 0; tick(); tick();
    chk("R3 switch to input", evt_status[3], '0);
    fall_en[40] = 1; pin_level[40] = 1; tick(); tick();
    chk("R7 shared set", N'(irq_shared), N'(1));
    clr_mask = '1; tick();                                    // no strobe
    chk("R4 mask without strobe", evt_status[40], N'(1));
    clr_strobe = 1; clr_mask = N'(1); tick(); clr_strobe = 0;
    chk("R4 clear bit0 only", evt_status[1:0], N'(2'b10));
    clr_strobe = 1; clr_mask = '0; clr_mask[7] = 1; clr_mask[40] = 1;
    pin_level[7] = 1; pin_level[40] = 0; tick(); clr_strobe = 0;
    chk("R5 rise beats clear", evt_status[7], N'(1));
    chk("R5 fall beats clear", evt_status[40], N'(1));
    clr_strobe = 1; clr_mask = '1; tick(); clr_strobe = 0;
    chk("R4 clear all", evt_status, '0);
    core_halted = 1; pin_level[116] = 1; tick(); tick();
    chk("R9 absent pin status", evt_status[116], '0);
    chk("R9 absent pin wake", N'(wake_req), N'(0));
    pin_level[113] = 1; tick();
    chk("R8 wake pulse", N'(wake_req), N'(1));
    tick();
    chk("R8 single cycle", N'(wake_req), N'(0));
    pin_level[2] = 1; tick();
    chk("R8 non-wake pin", N'(wake_req), N'(0));
    core_halted = 0; pin_level[0] = 0; tick();
    chk("R8 not halted", N'(wake_req), N'(0));
    for (int k = 0; k < 400; k++) begin
      pin_level  = {$urandom, $urandom, $urandom, $urandom};
      pin_is_out = {$urandom, $urandom, $urandom, $urandom};
      rise_en    = {$urandom, $urandom, $urandom, $urandom};
      fall_en    = {$urandom, $urandom, $urandom, $urandom};
      clr_mask   = {$urandom, $urandom, $urandom, $urandom};
      clr_strobe = $urandom % 3 == 0;
      core_halted = $urandom % 2 == 0;
      tick();
    end
    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule